// File: doc/BRIEF.md
# Asymmetric Input Debouncer with Event Output

This block cleans up one noisy input line, such as a button or a mechanical contact. The raw level first passes through a two-flop synchronizer. A free-running prescaler divides the clock into a sample tick, nominally one per millisecond. The block holds a debounced state. When the synchronized level differs from that state, a sampling run starts. The run takes one sample per tick and accepts the new level only after enough consecutive samples disagree with the held state. The number of samples needed for a rise and for a fall are set separately.

When a change is accepted, the held state flips, the run ends, and a one-cycle event pulse may fire. In single-edge mode the pulse fires only when the new level equals the configured active level. In double-edge mode it fires on every accepted change. A read output gives the held state, inverted when the line is configured active-low. An init strobe loads the held state directly from the synchronized input and cancels any run in progress.

Top module: `deb_asym_filter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the held state is cleared to 0, the sampler goes idle, the counter is loaded with the rise count, and `event_o` is 0. As a result, `read_o` equals `active_low` during reset.
- R2: `raw_in` is seen through two flops. Samples are taken only on a prescaler tick, one every `TICK_DIV` clock cycles counted from reset. A run starts on the edge after the synchronized level differs from the held state while idle.
- R3: A change from 0 to 1 is accepted on the `RISE_SAMPLES`-th consecutive tick whose sample is 1.
- R4: A change from 1 to 0 is accepted on the `FALL_SAMPLES`-th consecutive tick whose sample is 0.
- R5: A sample that agrees with the held state reloads the counter for the direction leaving that state, and the run continues. A pulse shorter than the threshold therefore leaves the held state unchanged, and disagreeing samples separated by an agreeing one never add up.
- R6: With `dual_edge` = 0, an accepted change raises `event_o` only when the new level XOR `active_low` is 1.
- R7: With `dual_edge` = 1, every accepted change raises `event_o`.
- R8: `event_o` is high for exactly one cycle. It rises on the same edge at which `stable_o` takes its new value.
- R9: An `init_strobe` high at an edge loads `stable_o` with the synchronized input, reloads the counter for that level, and ends any run. It raises no event.
- R10: `read_o` equals `stable_o` XOR `active_low` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| raw_in | input | 1 | Asynchronous raw input line |
| active_low | input | 1 | 1: the line is asserted when low |
| dual_edge | input | 1 | 1: signal an event on both change directions |
| init_strobe | input | 1 | Load the held state from the synchronized input |
| stable_o | output | 1 | Debounced held state (physical level) |
| read_o | output | 1 | Held state corrected for active-low |
| event_o | output | 1 | One-cycle pulse on a qualifying accepted change |

## Verification
The filter is driven with long steady levels in each direction, so the separate rise and fall counts are exercised. It is also driven with pulses shorter than the threshold, and with a burst of short high pulses split by brief low gaps. Only the reload rule keeps that burst from being accepted. Each change direction is repeated under every combination of `active_low` and `dual_edge`, so the pulse gate can be told apart from a plain change detector. An init strobe is applied in the middle of a run. Random hold lengths, mixed with occasional mode flips and init strobes, are compared cycle by cycle against a reference model in the bench. That model covers the tick phase and the synchronizer delay.

// File: rtl/deb_pkg.sv
// Shared types and helpers for the asymmetric debouncer.
// Assumes: single-bit input line, one sampling run at a time.
package deb_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } deb_phase_e;

    // Decide whether an accepted change to new_lvl is reported as an event.
    function automatic logic event_gate(input logic new_lvl,
                                        input logic act_low,
                                        input logic both_edges);
        return both_edges | (new_lvl ^ act_low);
    endfunction

endpackage

// File: rtl/deb_tick_gen.sv
// Free-running prescaler: one-cycle tick every TICK_DIV clocks.
// Assumes TICK_DIV >= 2; counter restarts from zero on reset.
module deb_tick_gen #(
    parameter int TICK_DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [DW-1:0] div_q;

    assign tick_o = (div_q == DW'(TICK_DIV - 1));

    // Count clocks, wrapping on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      div_q <= '0;
        else if (tick_o) div_q <= '0;
        else             div_q <= div_q + DW'(1);
    end
endmodule

// File: rtl/deb_sync2.sv
// Two-flop synchronizer for an asynchronous single-bit input.
// Assumes the input is slow relative to the clock; reset value 0.
module deb_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic meta_q;
    logic sync_q;

    assign sync_o = sync_q;

    // Shift the raw level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end
endmodule

// File: rtl/deb_filter_core.sv
// Debounce state machine: holds the accepted level and counts disagreeing
// samples on each tick while a run is active. Separate thresholds per
// direction. Assumes lvl_i is already synchronous; thresholds >= 1.
module deb_filter_core
    import deb_pkg::*;
#(
    parameter int RISE_SAMPLES = 2,
    parameter int FALL_SAMPLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic tick_i,
    input  logic act_low_i,
    input  logic both_edges_i,
    input  logic init_i,
    output logic stable_o,
    output logic event_o,
    output logic busy_o,
    output logic [$clog2((RISE_SAMPLES > FALL_SAMPLES ? RISE_SAMPLES : FALL_SAMPLES) + 1)-1:0] cnt_o
);
    localparam int MAXS = (RISE_SAMPLES > FALL_SAMPLES) ? RISE_SAMPLES : FALL_SAMPLES;
    localparam int CW   = $clog2(MAXS + 1);

    deb_phase_e    phase_q;
    logic          stable_q;
    logic          evt_q;
    logic [CW-1:0] cnt_q;

    // Counter value for the change leaving level lvl.
    function automatic logic [CW-1:0] reload(input logic lvl);
        return lvl ? CW'(FALL_SAMPLES) : CW'(RISE_SAMPLES);
    endfunction

    assign stable_o = stable_q;
    assign event_o  = evt_q;
    assign busy_o   = (phase_q == PH_RUN);
    assign cnt_o    = cnt_q;

    // Run control, sample counting, acceptance and event generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            stable_q <= 1'b0;
            evt_q    <= 1'b0;
            cnt_q    <= CW'(RISE_SAMPLES);
        end else begin
            evt_q <= 1'b0;
            if (init_i) begin
                stable_q <= lvl_i;
                cnt_q    <= reload(lvl_i);
                phase_q  <= PH_IDLE;
            end else if (phase_q == PH_IDLE) begin
                if (lvl_i != stable_q) phase_q <= PH_RUN;
            end else if (tick_i) begin
                if (lvl_i == stable_q) begin
                    cnt_q <= reload(stable_q);
                end else if (cnt_q == CW'(1)) begin
                    stable_q <= lvl_i;
                    cnt_q    <= reload(lvl_i);
                    phase_q  <= PH_IDLE;
                    evt_q    <= event_gate(lvl_i, act_low_i, both_edges_i);
                end else begin
                    cnt_q <= cnt_q - CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/deb_asym_filter.sv
// Top: synchronizer, sample prescaler and debounce core for one line.
// Assumes raw_in is asynchronous; TICK_DIV is clocks per sample period.
module deb_asym_filter #(
    parameter int TICK_DIV     = 50000,
    parameter int RISE_SAMPLES = 2,
    parameter int FALL_SAMPLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic active_low,
    input  logic dual_edge,
    input  logic init_strobe,
    output logic stable_o,
    output logic read_o,
    output logic event_o
);
    localparam int MAXS = (RISE_SAMPLES > FALL_SAMPLES) ? RISE_SAMPLES : FALL_SAMPLES;
    localparam int CW   = $clog2(MAXS + 1);

    logic          sync_lvl;
    logic          tick;
    logic          run_flag;
    logic [CW-1:0] cnt_w;

    deb_sync2 u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (sync_lvl)
    );

    deb_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    deb_filter_core #(
        .RISE_SAMPLES (RISE_SAMPLES),
        .FALL_SAMPLES (FALL_SAMPLES)
    ) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .lvl_i        (sync_lvl),
        .tick_i       (tick),
        .act_low_i    (active_low),
        .both_edges_i (dual_edge),
        .init_i       (init_strobe),
        .stable_o     (stable_o),
        .event_o      (event_o),
        .busy_o       (run_flag),
        .cnt_o        (cnt_w)
    );

    // Polarity-corrected view of the held state.
    assign read_o = stable_o ^ active_low;
endmodule

// File: rtl/deb_asym_filter_chk.sv
// Checker for the debouncer, bound into the top module.
// Assumes synchronous active-low reset; every property is disabled in reset.
module deb_asym_filter_chk #(
    parameter int RISE_SAMPLES = 2,
    parameter int FALL_SAMPLES = 2,
    parameter int CW           = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          init_strobe,
    input logic          active_low,
    input logic          dual_edge,
    input logic          tick,
    input logic          sync_lvl,
    input logic          running,
    input logic [CW-1:0] cnt,
    input logic          stable,
    input logic          evt
);
    // R8: the event coincides with a change of the held state.
    p_event_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evt && $past(rst_n) |-> stable != $past(stable));

    // R8: the event lasts one cycle.
    p_event_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);

    // R2: the held state moves only on a tick or on init.
    p_change_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (stable != $past(stable)) && !$past(init_strobe) |-> $past(tick));

    // R6: in single-edge mode the event marks arrival at the active level.
    p_event_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt && $past(rst_n) && !$past(dual_edge) |-> (stable ^ $past(active_low)));

    // R9: init loads the synchronized level and raises no event.
    p_init_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(init_strobe) |-> (stable == $past(sync_lvl)) && !evt && !running);

    // R5: while idle the counter holds the threshold for leaving the held level.
    p_idle_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> cnt == (stable ? CW'(FALL_SAMPLES) : CW'(RISE_SAMPLES)));
endmodule

bind deb_asym_filter deb_asym_filter_chk #(
    .RISE_SAMPLES (RISE_SAMPLES),
    .FALL_SAMPLES (FALL_SAMPLES),
    .CW           (CW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_strobe (init_strobe),
    .active_low  (active_low),
    .dual_edge   (dual_edge),
    .tick        (tick),
    .sync_lvl    (sync_lvl),
    .running     (run_flag),
    .cnt         (cnt_w),
    .stable      (stable_o),
    .evt         (event_o)
);

// File: tb/tb_deb_asym_filter.sv
module tb_deb_asym_filter;
    localparam int TICK_DIV = 4;
    localparam int RISE     = 3;
    localparam int FALL     = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic raw = 1'b0;
    logic alow = 1'b0;
    logic dbl = 1'b0;
    logic init = 1'b0;
    logic stable_o, read_o, event_o;

    int checks = 0;
    int fails  = 0;
    int ev_cnt = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    // Reference model state
    logic m_s1, m_s2, m_st, m_run, m_evt, m_tk;
    int   m_div, m_cnt;

    always #10 clk = ~clk;

    deb_asym_filter #(
        .TICK_DIV     (TICK_DIV),
        .RISE_SAMPLES (RISE),
        .FALL_SAMPLES (FALL)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .raw_in      (raw),
        .active_low  (alow),
        .dual_edge   (dbl),
        .init_strobe (init),
        .stable_o    (stable_o),
        .read_o      (read_o),
        .event_o     (event_o)
    );

    function automatic int reload(input logic lvl);
        return lvl ? FALL : RISE;
    endfunction

    function automatic logic gate(input logic lvl, input logic al, input logic de);
        return de | (lvl ^ al);
    endfunction

    // Reference model, advanced on each rising edge from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_div = 0; m_st = 0;
            m_cnt = RISE; m_run = 0; m_evt = 0;
        end else begin
            m_tk  = (m_div == TICK_DIV - 1);
            m_evt = 0;
            if (init) begin
                m_st = m_s2; m_cnt = reload(m_s2); m_run = 0;
            end else if (!m_run) begin
                if (m_s2 != m_st) m_run = 1;
            end else if (m_tk) begin
                if (m_s2 == m_st) m_cnt = reload(m_st);
                else if (m_cnt == 1) begin
                    m_st = m_s2; m_cnt = reload(m_s2); m_run = 0;
                    m_evt = gate(m_s2, alow, dbl);
                end else m_cnt = m_cnt - 1;
            end
            m_div = m_tk ? 0 : m_div + 1;
            m_s2 = m_s1; m_s1 = raw;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: move to the falling edge, compare against the model.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (event_o) ev_cnt++;
            if (rst_n) begin
                check("R2/R3/R4/R5 stable vs model", stable_o, m_st);
                check("R6/R7/R8 event vs model", event_o, m_evt);
                check("R10 read", read_o, stable_o ^ alow);
            end
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 100000);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state, read follows active_low
        alow = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 stable in reset", stable_o, 0);
        check("R1 event in reset", event_o, 0);
        check("R1 read in reset", read_o, 1);
        alow = 1'b0;
        @(negedge clk);
        check("R1 read in reset low", read_o, 0);
        rst_n = 1'b1;
        step(10);

        // R3: rise needs RISE samples, event with active high (R6)
        raw = 1; ev_cnt = 0;
        step(8);
        check("R3 not yet accepted", stable_o, 0);
        step(32);
        check("R3 rise accepted", stable_o, 1);
        check("R6 event on rise active-high", ev_cnt, 1);

        // R4: fall, no event in active-high single-edge mode (R6)
        raw = 0; ev_cnt = 0;
        step(40);
        check("R4 fall accepted", stable_o, 0);
        check("R6 no event on fall active-high", ev_cnt, 0);

        // R5: short pulse is rejected
        raw = 1; step(5); raw = 0; ev_cnt = 0;
        step(40);
        check("R5 short pulse rejected", stable_o, 0);
        check("R5 no event from glitch", ev_cnt, 0);

        // R5: disagreeing samples split by an agreeing one do not add up
        raw = 1; step(7); raw = 0; step(5); raw = 1; step(7); raw = 0;
        step(40);
        check("R5 reload between bursts", stable_o, 0);

        // R6 with active-low: event on fall only
        alow = 1; raw = 1; ev_cnt = 0;
        step(40);
        check("R6 no event rise active-low", ev_cnt, 0);
        check("R10 read active-low high", read_o, 0);
        raw = 0; ev_cnt = 0;
        step(40);
        check("R6 event fall active-low", ev_cnt, 1);
        check("R10 read active-low low", read_o, 1);

        // R7: dual edge fires both ways
        alow = 0; dbl = 1; raw = 1; ev_cnt = 0;
        step(40);
        check("R7 event on rise", ev_cnt, 1);
        raw = 0; ev_cnt = 0;
        step(40);
        check("R7 event on fall", ev_cnt, 1);
        dbl = 0;

        // R9: init mid-run loads the synchronized level, no event
        raw = 1; step(5);
        init = 1; ev_cnt = 0;
        step(1);
        init = 0;
        step(1);
        check("R9 init loads level", stable_o, 1);
        step(40);
        check("R9 no event after init", ev_cnt, 0);
        raw = 0; step(3);
        init = 1; step(1); init = 0; step(1);
        check("R9 init loads low", stable_o, 0);

        // Random segments against the model (R2..R10)
        for (int s = 0; s < 300; s++) begin
            raw = 1'($urandom % 2);
            if ($urandom % 16 == 0) alow = ~alow;
            if ($urandom % 16 == 0) dbl = ~dbl;
            if ($urandom % 32 == 0) begin
                init = 1; step(1); init = 0;
            end
            step(1 + ($urandom % 20));
        end

        finish_run();
    end
endmodule